// File: doc/BRIEF.md
# Memory-Mapped Pixel Buffer with Frame Capture Strobe

This block is a bus slave that gives a small processor a 128 by 96 pixel buffer of RGB565 halfwords plus two control registers. Software draws by issuing ordinary halfword stores into a fixed address window. There is no command protocol. Each 32-bit storage word holds two neighbouring pixels.

When a frame is finished, software stores its frame number to a frame-ready register. That store raises a one-cycle strobe and latches the number onto a sequence output. A capture agent, such as a testbench harness, uses the strobe to snapshot the buffer through a separate read port. The capture port can run while the processor keeps drawing.

A store of 1 to the halt register raises a sticky halt output that stops the processor. The final picture stays readable on both read paths after halt.

Top module: `fb_mmio_slave`

## Requirements
- R1: While rst_ni is low, frame_strobe_o, frame_seq_o, halt_o, bus_rvalid_o and bus_rdata_o are all 0.
- R2: Pixel (x, y) lives at byte address 0x00800000 + 2*(y*128 + x), inside 32-bit word (y*128+x)>>1. Even x occupies bits 15:0 and odd x occupies bits 31:16. A write stores only the byte lanes whose bus_be_i bit is set.
- R3: A read request whose address is inside the pixel window raises bus_rvalid_o on the following cycle, with bus_rdata_o holding the addressed 32-bit word.
- R4: A write to address 0x10001ffc raises frame_strobe_o for exactly the following cycle. In that same cycle frame_seq_o takes the full 32-bit write data, and it holds that value until the next such write.
- R5: A read of address 0x10001ffc returns the latched frame_seq_o value one cycle later.
- R6: A write of data 1 to the halt address (parameter, default 0x10001ff8) sets halt_o from the next cycle on. Any other written value leaves halt_o unchanged. Once set, halt_o stays set until reset. A read of the halt address returns halt_o in bit 0.
- R7: Writes to addresses outside the pixel window and the two control registers change no pixel and no output. Reads of such addresses return bus_rvalid_o = 1 with bus_rdata_o = 0 one cycle later.
- R8: cap_rdata_o shows, one cycle later, the word that cap_addr_i selected. If the bus writes that same word in that same cycle, the capture port returns the value from before the write.
- R9: After halt_o is set, the buffer contents remain readable, unchanged, through both the bus and the capture port.
- R10: The first byte past the window (0x00800000 + 24576) decodes as outside the window. The last pixel (127, 95) decodes as inside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus transfer request this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 32 | Byte address |
| bus_wdata_i | input | 32 | Write data, placed on the lanes selected by the byte enables |
| bus_be_i | input | 4 | Byte enables for writes |
| bus_rdata_o | output | 32 | Read data, valid while bus_rvalid_o is high |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| cap_addr_i | input | CAP_AW (13) | Capture port word index |
| cap_rdata_o | output | 32 | Capture port word, one cycle after the index |
| frame_strobe_o | output | 1 | One-cycle pulse per frame-ready write |
| frame_seq_o | output | 32 | Last frame number written |
| halt_o | output | 1 | Sticky processor stop request |

## Verification
The bench fills the whole buffer and then issues random halfword stores to both lanes. It checks that the neighbouring pixel in the same word survives each store; a design that ignored byte enables would smear one pixel over both halves. Directed cases cover several points:
- the words just outside each end of the window, where an off-by-one decode would corrupt the first or last word;
- a capture read that collides with a bus write to the same word, where a write-first RAM would return the new data too early;
- frame-ready writes, where a level-style strobe would stay high for more than one cycle;
- halt writes of values other than 1, which a sloppy decode would treat as a halt.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic [1:0] {RD_NONE, RD_PIX, RD_FRAME, RD_HALT} rd_sel_e;

  typedef struct packed {
    logic pix;
    logic frame;
    logic halt;
  } hit_t;
endpackage

// File: rtl/fb_addr_decode.sv
module fb_addr_decode
  import fb_pkg::*;
#(
  parameter logic [31:0] PIX_BASE   = 32'h0080_0000,
  parameter int unsigned WIN_BYTES  = 24576,
  parameter logic [31:0] FRAME_ADDR = 32'h1000_1ffc,
  parameter logic [31:0] HALT_ADDR  = 32'h1000_1ff8,
  parameter int unsigned AW         = 13
) (
  input  logic [31:0]   addr_i,
  output hit_t          hit_o,
  output logic [AW-1:0] word_o
);
  logic [31:0] off;

  always_comb begin
    off       = addr_i - PIX_BASE;
    hit_o.pix   = (addr_i >= PIX_BASE) && (off < WIN_BYTES);
    hit_o.frame = (addr_i[31:2] == FRAME_ADDR[31:2]);
    hit_o.halt  = (addr_i[31:2] == HALT_ADDR[31:2]);
    word_o    = off[AW+1:2];
  end
endmodule

// File: rtl/fb_pixel_ram.sv
module fb_pixel_ram #(
  parameter int unsigned DEPTH = 6144,
  parameter int unsigned AW    = 13,
  parameter int unsigned LANES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [LANES-1:0]   be_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [8*LANES-1:0] wdata_i,
  input  logic               re_a_i,
  input  logic [AW-1:0]      raddr_a_i,
  output logic [8*LANES-1:0] rdata_a_o,
  input  logic [AW-1:0]      raddr_b_i,
  output logic [8*LANES-1:0] rdata_b_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic b_in_range;
  assign b_in_range = (raddr_b_i <= LAST);

  // one storage array per byte lane so each lane has a single writer
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] qa, qb;

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) mem[waddr_i] <= wdata_i[8*g +: 8];
    end

    // read-before-write: both ports see the pre-write value on a collision
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        qa <= '0;
        qb <= '0;
      end else begin
        if (re_a_i) qa <= mem[raddr_a_i];
        qb <= b_in_range ? mem[raddr_b_i] : 8'h00;
      end
    end

    assign rdata_a_o[8*g +: 8] = qa;
    assign rdata_b_o[8*g +: 8] = qb;
  end
endmodule

// File: rtl/fb_ctrl_regs.sv
module fb_ctrl_regs (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        frame_we_i,
  input  logic        halt_we_i,
  input  logic [31:0] wdata_i,
  output logic        strobe_o,
  output logic [31:0] seq_o,
  output logic        halt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_o <= 1'b0;
      seq_o    <= '0;
      halt_o   <= 1'b0;
    end else begin
      strobe_o <= frame_we_i;
      if (frame_we_i) seq_o <= wdata_i;
      if (halt_we_i && wdata_i == 32'd1) halt_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fb_mmio_slave.sv
module fb_mmio_slave
  import fb_pkg::*;
#(
  parameter int unsigned WIDTH_PX   = 128,
  parameter int unsigned HEIGHT_PX  = 96,
  parameter logic [31:0] PIX_BASE   = 32'h0080_0000,
  parameter logic [31:0] FRAME_ADDR = 32'h1000_1ffc,
  parameter logic [31:0] HALT_ADDR  = 32'h1000_1ff8,
  parameter int unsigned CAP_AW     = $clog2(WIDTH_PX * HEIGHT_PX / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic [3:0]        bus_be_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic [CAP_AW-1:0] cap_addr_i,
  output logic [31:0]       cap_rdata_o,
  output logic              frame_strobe_o,
  output logic [31:0]       frame_seq_o,
  output logic              halt_o
);
  localparam int unsigned WIN_BYTES = WIDTH_PX * HEIGHT_PX * 2;
  localparam int unsigned DEPTH     = WIN_BYTES / 4;

  hit_t              hit;
  logic [CAP_AW-1:0] word;
  logic              wr, rd;
  logic [31:0]       pix_rdata;
  rd_sel_e           sel_d, sel_q;
  logic [31:0]       ctrl_q;
  logic              rvalid_q;

  assign wr = bus_req_i &  bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;

  fb_addr_decode #(
    .PIX_BASE  (PIX_BASE),
    .WIN_BYTES (WIN_BYTES),
    .FRAME_ADDR(FRAME_ADDR),
    .HALT_ADDR (HALT_ADDR),
    .AW        (CAP_AW)
  ) u_dec (
    .addr_i(bus_addr_i),
    .hit_o (hit),
    .word_o(word)
  );

  fb_pixel_ram #(
    .DEPTH(DEPTH),
    .AW   (CAP_AW),
    .LANES(4)
  ) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr & hit.pix),
    .be_i     (bus_be_i),
    .waddr_i  (word),
    .wdata_i  (bus_wdata_i),
    .re_a_i   (rd & hit.pix),
    .raddr_a_i(word),
    .rdata_a_o(pix_rdata),
    .raddr_b_i(cap_addr_i),
    .rdata_b_o(cap_rdata_o)
  );

  fb_ctrl_regs u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_we_i(wr & hit.frame),
    .halt_we_i (wr & hit.halt),
    .wdata_i   (bus_wdata_i),
    .strobe_o  (frame_strobe_o),
    .seq_o     (frame_seq_o),
    .halt_o    (halt_o)
  );

  always_comb begin
    sel_d = RD_NONE;
    if (hit.pix)        sel_d = RD_PIX;
    else if (hit.frame) sel_d = RD_FRAME;
    else if (hit.halt)  sel_d = RD_HALT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= RD_NONE;
      ctrl_q   <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      sel_q    <= rd ? sel_d : RD_NONE;
      if (rd) ctrl_q <= hit.frame ? frame_seq_o : {31'd0, halt_o};
    end
  end

  always_comb begin
    unique case (sel_q)
      RD_PIX:           bus_rdata_o = pix_rdata;
      RD_FRAME, RD_HALT: bus_rdata_o = ctrl_q;
      default:          bus_rdata_o = '0;
    endcase
  end

  assign bus_rvalid_o = rvalid_q;
endmodule

// File: rtl/fb_mmio_slave_chk.sv
module fb_mmio_slave_chk #(
  parameter logic [31:0] PIX_BASE   = 32'h0080_0000,
  parameter int unsigned WIN_BYTES  = 24576,
  parameter logic [31:0] FRAME_ADDR = 32'h1000_1ffc,
  parameter logic [31:0] HALT_ADDR  = 32'h1000_1ff8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_req_i,
  input logic        bus_we_i,
  input logic [31:0] bus_addr_i,
  input logic [31:0] bus_wdata_i,
  input logic [31:0] bus_rdata_o,
  input logic        bus_rvalid_o,
  input logic        frame_strobe_o,
  input logic [31:0] frame_seq_o,
  input logic        halt_o
);
  logic fw, hw1, rd_void;
  logic [31:0] off;

  assign off     = bus_addr_i - PIX_BASE;
  assign fw      = bus_req_i && bus_we_i && (bus_addr_i[31:2] == FRAME_ADDR[31:2]);
  assign hw1     = bus_req_i && bus_we_i && (bus_addr_i[31:2] == HALT_ADDR[31:2])
                   && (bus_wdata_i == 32'd1);
  assign rd_void = bus_req_i && !bus_we_i
                   && !((bus_addr_i >= PIX_BASE) && (off < WIN_BYTES))
                   && (bus_addr_i[31:2] != FRAME_ADDR[31:2])
                   && (bus_addr_i[31:2] != HALT_ADDR[31:2]);

  p_strobe_after_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw |=> frame_strobe_o);
  p_strobe_has_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_strobe_o |-> $past(fw));
  p_seq_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw |=> frame_seq_o == $past(bus_wdata_i));
  p_seq_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fw |=> $stable(frame_seq_o));
  p_halt_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw1 |=> halt_o);
  p_halt_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  p_halt_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> $past(hw1));
  p_rvalid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i) |=> bus_rvalid_o);
  p_void_read_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_void |=> (bus_rvalid_o && bus_rdata_o == 32'd0));
endmodule

bind fb_mmio_slave fb_mmio_slave_chk #(
  .PIX_BASE  (PIX_BASE),
  .WIN_BYTES (WIN_BYTES),
  .FRAME_ADDR(FRAME_ADDR),
  .HALT_ADDR (HALT_ADDR)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_req_i     (bus_req_i),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_rdata_o   (bus_rdata_o),
  .bus_rvalid_o  (bus_rvalid_o),
  .frame_strobe_o(frame_strobe_o),
  .frame_seq_o   (frame_seq_o),
  .halt_o        (halt_o)
);

// File: tb/fb_mmio_slave_bench.sv
module fb_mmio_slave_bench;
  localparam int unsigned W     = 128;
  localparam int unsigned H     = 96;
  localparam int unsigned WORDS = W * H / 2;
  localparam int unsigned AW    = $clog2(WORDS);
  localparam logic [31:0] BASE  = 32'h0080_0000;
  localparam logic [31:0] FRAME = 32'h1000_1ffc;
  localparam logic [31:0] HALT  = 32'h1000_1ff8;
  localparam logic [31:0] PAST  = BASE + W * H * 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni;
  logic          req, we;
  logic [31:0]   addr, wdata;
  logic [3:0]    be;
  logic [31:0]   rdata;
  logic          rvalid;
  logic [AW-1:0] cap_addr;
  logic [31:0]   cap_rdata;
  logic          strobe;
  logic [31:0]   seq;
  logic          halt;

  fb_mmio_slave u_fb_mmio_slave (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_be_i(be), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .cap_addr_i(cap_addr), .cap_rdata_o(cap_rdata),
    .frame_strobe_o(strobe), .frame_seq_o(seq), .halt_o(halt)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] shadow [WORDS];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] m);
    for (int b = 0; b < 4; b++) if (m[b]) o[8*b +: 8] = n[8*b +: 8];
    return o;
  endfunction

  function automatic logic [31:0] pix_addr(int unsigned x, int unsigned y);
    return BASE + 32'(2 * (y * W + x));
  endfunction

  task automatic bus_write(logic [31:0] a, logic [31:0] d, logic [3:0] m);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = m;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(logic [31:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata; v = rvalid;
  endtask

  task automatic cap_read(logic [AW-1:0] i, output logic [31:0] d);
    @(negedge clk);
    cap_addr = i;
    @(negedge clk);
    d = cap_rdata;
  endtask

  task automatic frame_write(logic [31:0] n);
    bus_write(FRAME, n, 4'hf);
    check("R4 strobe", {31'd0, strobe}, 32'd1);
    check("R4 seq", seq, n);
    @(negedge clk);
    check("R4 strobe one cycle", {31'd0, strobe}, 32'd0);
    check("R4 seq hold", seq, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, old, nv;
    logic v;
    void'($urandom(32'd20240));
    rst_ni = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; be = '0; cap_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 strobe", {31'd0, strobe}, 32'd0);
    check("R1 seq", seq, 32'd0);
    check("R1 halt", {31'd0, halt}, 32'd0);
    check("R1 rvalid", {31'd0, rvalid}, 32'd0);
    check("R1 rdata", rdata, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < int'(WORDS); i++) begin
      nv = 32'(i) * 32'h9e37_79b1 + 32'h0000_1234;
      bus_write(BASE + 32'(4 * i), nv, 4'hf);
      shadow[i] = nv;
    end
    bus_read(BASE, d, v);
    check("R3 rvalid", {31'd0, v}, 32'd1);
    check("R3 word 0", d, shadow[0]);
    cap_read(AW'(WORDS - 1), d);
    check("R8 last word", d, shadow[WORDS-1]);

    for (int i = 0; i < 400; i++) begin
      int unsigned x, y, p;
      logic [15:0] h;
      logic [3:0] m;
      x = $urandom % W; y = $urandom % H; h = 16'($urandom);
      p = y * W + x;
      m = (x % 2 == 1) ? 4'b1100 : 4'b0011;
      bus_write(pix_addr(x, y), {h, h}, m);
      shadow[p/2] = merge(shadow[p/2], {h, h}, m);
      if (i % 2 == 0) begin
        bus_read(BASE + 32'(4 * (p / 2)), d, v);
        check("R2 lane via bus", d, shadow[p/2]);
      end else begin
        cap_read(AW'(p / 2), d);
        check("R2 lane via capture", d, shadow[p/2]);
      end
      if (i % 100 == 99) frame_write(32'($urandom));
    end

    frame_write(32'hcafe_0007);
    bus_read(FRAME, d, v);
    check("R5 frame readback", d, 32'hcafe_0007);
    frame_write(32'd8);
    bus_read(FRAME, d, v);
    check("R5 frame readback 2", d, 32'd8);

    bus_write(32'h0070_0000, 32'hffff_ffff, 4'hf);
    check("R7 no strobe", {31'd0, strobe}, 32'd0);
    bus_write(BASE - 4, 32'hffff_ffff, 4'hf);
    cap_read('0, d);
    check("R7 word 0 untouched", d, shadow[0]);
    bus_read(32'h2000_0000, d, v);
    check("R7 void read valid", {31'd0, v}, 32'd1);
    check("R7 void read zero", d, 32'd0);
    check("R7 seq untouched", seq, 32'd8);

    bus_write(PAST, 32'hdead_beef, 4'hf);
    cap_read(AW'(WORDS - 1), d);
    check("R10 last word untouched", d, shadow[WORDS-1]);
    bus_read(PAST, d, v);
    check("R10 past end reads zero", d, 32'd0);
    bus_write(pix_addr(W - 1, H - 1), 32'h5a5a_5a5a, 4'b1100);
    shadow[WORDS-1] = merge(shadow[WORDS-1], 32'h5a5a_5a5a, 4'b1100);
    bus_read(pix_addr(W - 2, H - 1), d, v);
    check("R10 last pixel", d, shadow[WORDS-1]);

    old = shadow[100];
    nv = ~old;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = BASE + 32'(4 * 100); wdata = nv; be = 4'hf;
    cap_addr = AW'(100);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check("R8 collision old", cap_rdata, old);
    @(negedge clk);
    check("R8 after collision new", cap_rdata, nv);
    shadow[100] = nv;

    bus_write(HALT, 32'd5, 4'hf);
    check("R6 halt other value", {31'd0, halt}, 32'd0);
    bus_write(HALT, 32'd1, 4'hf);
    check("R6 halt set", {31'd0, halt}, 32'd1);
    bus_write(HALT, 32'd0, 4'hf);
    check("R6 halt sticky", {31'd0, halt}, 32'd1);
    frame_write(32'd9);
    check("R6 halt after frame", {31'd0, halt}, 32'd1);
    bus_read(HALT, d, v);
    check("R6 halt readback", d, 32'd1);

    for (int i = 0; i < 20; i++) begin
      int unsigned k;
      k = $urandom % WORDS;
      bus_read(BASE + 32'(4 * k), d, v);
      check("R9 bus after halt", d, shadow[k]);
      cap_read(AW'(k), d);
      check("R9 capture after halt", d, shadow[k]);
    end

    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 halt cleared", {31'd0, halt}, 32'd0);
    check("R1 seq cleared", seq, 32'd0);
    check("R1 strobe cleared", {31'd0, strobe}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule